// File: doc/BRIEF.md
# HDLC Frame Transmitter

This block turns a queue of message bytes into a bit-serial HDLC line signal. Software or an upstream engine writes bytes into a 64-entry transmit queue. Each byte is tagged when it is the final byte of its message. The transmitter wraps every message in 0x7E flags and inserts a zero after each run of five ones inside the message field. It then closes the message with a 16-bit frame check sequence. Between messages it sends idle fill, chosen as either 0x7E or 0xFF.

One output bit leaves per strobe on the bit-enable input, so the line rate is set entirely by the caller. Three static switches select the fill pattern and turn off zero insertion or check-sequence generation. A reset request flushes the queue and restarts the transmitter with an abort pattern. The block clears the request flag by itself once the restart is done.

Top module: `hdlc_frame_tx`

## Requirements
- R1: After `rstN` is released, `txBit` is 1, `rstPending` and `fifoFull` are 0. The first strobed bits are the abort byte 0x7F followed by idle fill, every byte sent least-significant bit first.
- R2: A one-cycle pulse on `rstSet` while `rstPending` is 0 makes `rstPending` read 1 in the next cycle and 0 in the cycle after. That clearing edge empties the queue and drops a write presented in the same cycle. The line then carries 0x7F followed by fill.
- R3: The idle fill byte is 0x7E when `fillSel` is 0 and 0xFF when `fillSel` is 1.
- R4: A queued message is sent as one fill byte, an opening 0x7E, the data bytes LSB first, the check sequence, a closing 0x7E and then fill.
- R5: The check sequence works on the data bits in line order, before zero insertion. A 16-bit register starts at 0xFFFF. For each bit b: f = reg[0] xor b, reg is shifted right by one, and if f is 1 the register is XORed with 0x8408. The inverted register is then sent bit 0 first through bit 15.
- R6: With `crcOff` at 1, the closing flag directly follows the last data byte.
- R7: With `stuffOff` at 0, a 0 is inserted after every five consecutive 1s among the data and check-sequence bits. This includes a trailing insertion just before the closing flag or abort. Flags, fill and abort are never stuffed.
- R8: With `stuffOff` at 1, data and check-sequence bits are sent without insertion.
- R9: If the queue is empty when a byte not tagged as message end has finished, the transmitter sends 0x7F and then fill.
- R10: The queue holds 64 entries. `fifoFull` is 1 exactly when 64 are held, and writes made while it is 1 are ignored.
- R11: `txBit` changes only on a clock edge at which `bitEn` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitEn | input | 1 | Bit strobe; one line bit per high cycle |
| wrEn | input | 1 | Queue write |
| wrData | input | 8 | Byte to queue |
| wrEom | input | 1 | Byte is the last of its message |
| fifoFull | output | 1 | Queue holds 64 entries |
| rstSet | input | 1 | Request a flush and transmitter restart |
| rstPending | output | 1 | Restart request in progress, self-clearing |
| fillSel | input | 1 | Idle fill: 0 gives 0x7E, 1 gives 0xFF |
| stuffOff | input | 1 | Disable zero insertion |
| crcOff | input | 1 | Disable the check sequence |
| txBit | output | 1 | Serial line output |

## Verification
A restart flush and a queue write can land on the same clock edge. The flush must win, so the written byte never appears on the line. The bench provokes this by presenting a tagged write in the cycle where `rstPending` reads 1. It then streams the line and expects only 0x7F followed by 0xFF fill, with no opening flag. A byte left in the queue from before the request must also be gone, and that is judged by the same stream.

// File: rtl/hdlc_tx_pkg.sv
package hdlc_tx_pkg;
  typedef enum logic [2:0] {SRC_FILL, SRC_FLAG, SRC_ABORT, SRC_FIFO, SRC_CRCLO, SRC_CRCHI} byteSrc_t;
  typedef enum logic [2:0] {ST_ABORT, ST_IDLE, ST_OPEN, ST_DATA, ST_CRC1, ST_CRC2, ST_CLOSE} txState_t;
  typedef struct packed {
    byteSrc_t src;
    logic     stuffable;
    logic     crcAcc;
    logic     crcClr;
    logic     flush;
  } txStrobe_t;
  localparam logic [7:0]  FLAG_BYTE  = 8'h7E;
  localparam logic [7:0]  ABORT_BYTE = 8'h7F;
  localparam logic [7:0]  ONES_BYTE  = 8'hFF;
  localparam logic [15:0] CRC_POLY   = 16'h8408;
  localparam logic [15:0] CRC_INIT   = 16'hFFFF;
  localparam int          STUFF_RUN  = 5;
endpackage

// File: rtl/hdlc_tx_datapath.sv
module hdlc_tx_datapath
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          bitEn,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  input  logic          wrEom,
  input  logic          fillSel,
  input  logic          stuffOff,
  input  txStrobe_t     strb,
  output logic          byteDone,
  output logic          fifoEmpty,
  output logic          fifoFull,
  output logic          curEom,
  output logic          txBit
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam int BW = $clog2(DW);

  logic [DW:0]   mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] count;
  logic [DW-1:0] shReg, nextByte;
  logic [BW-1:0] bitCnt;
  logic [2:0]    onesCnt;
  logic [15:0]   crc, crcNext, crcAfter;
  logic          doStuff, advance, push, pop, fb;

  assign fifoEmpty = (count == '0);
  assign fifoFull  = (count == CW'(DEPTH));
  assign doStuff   = !stuffOff && (onesCnt == 3'(STUFF_RUN));
  assign advance   = bitEn && !doStuff;
  assign byteDone  = advance && (bitCnt == BW'(DW - 1));
  assign push      = wrEn && !fifoFull && !strb.flush;
  assign pop       = byteDone && (strb.src == SRC_FIFO);

  // serial check-sequence step on the bit leaving now
  assign fb       = crc[0] ^ shReg[0];
  assign crcNext  = {1'b0, crc[15:1]} ^ (fb ? CRC_POLY : 16'h0000);
  assign crcAfter = (advance && strb.crcAcc) ? crcNext : crc;

  always_comb begin
    unique case (strb.src)
      SRC_FILL:  nextByte = fillSel ? ONES_BYTE : FLAG_BYTE;
      SRC_FLAG:  nextByte = FLAG_BYTE;
      SRC_ABORT: nextByte = ABORT_BYTE;
      SRC_FIFO:  nextByte = mem[rdPtr][DW-1:0];
      SRC_CRCLO: nextByte = ~crcAfter[7:0];
      SRC_CRCHI: nextByte = ~crc[15:8];
      default:   nextByte = FLAG_BYTE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= {wrEom, wrData};
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.flush) begin
      rdPtr <= '0;
      wrPtr <= '0;
      count <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == AW'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == AW'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
      count <= count + CW'(push) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBit   <= 1'b1;
      shReg   <= ABORT_BYTE;
      bitCnt  <= '0;
      onesCnt <= '0;
      curEom  <= 1'b0;
    end else if (strb.flush) begin
      shReg   <= ABORT_BYTE;
      bitCnt  <= '0;
      onesCnt <= '0;
      curEom  <= 1'b0;
    end else if (bitEn) begin
      if (doStuff) begin
        txBit   <= 1'b0;
        onesCnt <= '0;
      end else begin
        txBit   <= shReg[0];
        onesCnt <= (strb.stuffable && !stuffOff && shReg[0]) ? onesCnt + 3'd1 : 3'd0;
        if (byteDone) begin
          shReg  <= nextByte;
          bitCnt <= '0;
          if (pop) curEom <= mem[rdPtr][DW];
        end else begin
          shReg  <= shReg >> 1;
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.crcClr)      crc <= CRC_INIT;
    else if (advance && strb.crcAcc) crc <= crcNext;
  end
endmodule

// File: rtl/hdlc_tx_control.sv
module hdlc_tx_control
  import hdlc_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      byteDone,
  input  logic      fifoEmpty,
  input  logic      curEom,
  input  logic      crcOff,
  input  logic      rstSet,
  output logic      rstPending,
  output txStrobe_t strb
);
  txState_t state, nxt;
  byteSrc_t src;

  always_ff @(posedge clk) begin
    if (!rstN)           rstPending <= 1'b0;
    else if (rstPending) rstPending <= 1'b0;
    else if (rstSet)     rstPending <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN || rstPending) state <= ST_ABORT;
    else if (byteDone)       state <= nxt;
  end

  always_comb begin
    nxt = state;
    src = SRC_FILL;
    unique case (state)
      ST_ABORT: begin nxt = ST_IDLE; src = SRC_FILL; end
      ST_IDLE: begin
        if (!fifoEmpty) begin nxt = ST_OPEN; src = SRC_FLAG; end
        else            begin nxt = ST_IDLE; src = SRC_FILL; end
      end
      ST_OPEN: begin nxt = ST_DATA; src = SRC_FIFO; end
      ST_DATA: begin
        if (curEom) begin
          if (crcOff) begin nxt = ST_CLOSE; src = SRC_FLAG;  end
          else        begin nxt = ST_CRC1;  src = SRC_CRCLO; end
        end else if (fifoEmpty) begin
          nxt = ST_ABORT; src = SRC_ABORT;
        end else begin
          nxt = ST_DATA; src = SRC_FIFO;
        end
      end
      ST_CRC1:  begin nxt = ST_CRC2;  src = SRC_CRCHI; end
      ST_CRC2:  begin nxt = ST_CLOSE; src = SRC_FLAG;  end
      ST_CLOSE: begin nxt = ST_IDLE;  src = SRC_FILL;  end
      default:  begin nxt = ST_ABORT; src = SRC_ABORT; end
    endcase
  end

  always_comb begin
    strb.src       = src;
    strb.stuffable = (state == ST_DATA) || (state == ST_CRC1) || (state == ST_CRC2);
    strb.crcAcc    = (state == ST_DATA);
    strb.crcClr    = byteDone && (state == ST_IDLE) && (nxt == ST_OPEN);
    strb.flush     = rstPending;
  end
endmodule

// File: rtl/hdlc_frame_tx.sv
module hdlc_frame_tx
  import hdlc_tx_pkg::*;
#(
  parameter int DEPTH = 64
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitEn,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       wrEom,
  output logic       fifoFull,
  input  logic       rstSet,
  output logic       rstPending,
  input  logic       fillSel,
  input  logic       stuffOff,
  input  logic       crcOff,
  output logic       txBit
);
  txStrobe_t strb;
  logic byteDone, fifoEmpty, curEom;

  hdlc_tx_control u_ctl (
    .clk(clk), .rstN(rstN), .byteDone(byteDone), .fifoEmpty(fifoEmpty),
    .curEom(curEom), .crcOff(crcOff), .rstSet(rstSet),
    .rstPending(rstPending), .strb(strb)
  );

  hdlc_tx_datapath #(.DEPTH(DEPTH), .DW(8)) u_dp (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .wrEn(wrEn), .wrData(wrData),
    .wrEom(wrEom), .fillSel(fillSel), .stuffOff(stuffOff), .strb(strb),
    .byteDone(byteDone), .fifoEmpty(fifoEmpty), .fifoFull(fifoFull),
    .curEom(curEom), .txBit(txBit)
  );
endmodule

// File: rtl/hdlc_tx_chk.sv
module hdlc_tx_chk (
  input logic clk,
  input logic rstN,
  input logic bitEn,
  input logic wrEn,
  input logic rstSet,
  input logic rstPending,
  input logic fifoFull,
  input logic txBit
);
  // R11
  txbit_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !bitEn |=> $stable(txBit));

  // R2
  rst_selfclear_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPending |=> !rstPending);

  // R2
  rst_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rstSet && !rstPending) |=> rstPending);

  // R2
  flush_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    rstPending |=> !fifoFull);

  // R10
  full_by_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fifoFull) |-> $past(wrEn));
endmodule

bind hdlc_frame_tx hdlc_tx_chk u_chk (
  .clk(clk), .rstN(rstN), .bitEn(bitEn), .wrEn(wrEn), .rstSet(rstSet),
  .rstPending(rstPending), .fifoFull(fifoFull), .txBit(txBit)
);

// File: tb/sim_hdlc_frame_tx.sv
module sim_hdlc_frame_tx;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 64;

  logic clk = 1'b0, rstN = 1'b0, bitEn = 1'b0, wrEn = 1'b0, wrEom = 1'b0;
  logic rstSet = 1'b0, fillSel = 1'b0, stuffOff = 1'b0, crcOff = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic fifoFull, rstPending, txBit;

  int checks = 0, errors = 0;
  bit expBits [0:8191];
  int expLen, onesM;
  bit stuffM;
  logic [15:0] crcM;
  logic [7:0] dat [0:79];

  always #(CLK_PERIOD/2) clk = ~clk;

  hdlc_frame_tx #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rstN(rstN), .bitEn(bitEn), .wrEn(wrEn), .wrData(wrData),
    .wrEom(wrEom), .fifoFull(fifoFull), .rstSet(rstSet), .rstPending(rstPending),
    .fillSel(fillSel), .stuffOff(stuffOff), .crcOff(crcOff), .txBit(txBit)
  );

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic addByte(logic [7:0] b);
    for (int i = 0; i < 8; i++) begin expBits[expLen] = b[i]; expLen++; end
  endtask

  task automatic addField(bit b);
    expBits[expLen] = b; expLen++;
    if (stuffM) begin
      if (b) begin
        onesM++;
        if (onesM == 5) begin expBits[expLen] = 1'b0; expLen++; onesM = 0; end
      end else onesM = 0;
    end
  endtask

  task automatic crcStep(bit b);
    bit f;
    f = crcM[0] ^ b;
    crcM = crcM >> 1;
    if (f) crcM = crcM ^ 16'h8408;
  endtask

  task automatic buildExpect(int n, bit eom, int trail);
    logic [7:0] fill;
    logic [15:0] fcs;
    fill = fillSel ? 8'hFF : 8'h7E;
    expLen = 0;
    addByte(8'h7F);
    addByte(fill);
    if (n > 0) begin
      addByte(8'h7E);
      onesM = 0; stuffM = !stuffOff; crcM = 16'hFFFF;
      for (int k = 0; k < n; k++)
        for (int i = 0; i < 8; i++) begin crcStep(dat[k][i]); addField(dat[k][i]); end
      if (eom) begin
        if (!crcOff) begin
          fcs = ~crcM;
          for (int i = 0; i < 16; i++) addField(fcs[i]);
        end
        addByte(8'h7E);
      end else addByte(8'h7F);
    end
    for (int t = 0; t < trail; t++) addByte(fill);
  endtask

  task automatic stepBit(output logic b);
    @(negedge clk) bitEn = 1'b1;
    @(negedge clk) bitEn = 1'b0;
    b = txBit;
  endtask

  task automatic compareStream(string req, string what);
    int firstBad, gotV, expV;
    logic g;
    firstBad = -1; gotV = 0; expV = 0;
    for (int i = 0; i < expLen; i++) begin
      stepBit(g);
      if (g !== expBits[i] && firstBad < 0) begin
        firstBad = i; gotV = int'(g); expV = int'(expBits[i]);
      end
    end
    check(firstBad < 0, req, $sformatf("%s bit %0d", what, firstBad), gotV, expV);
  endtask

  task automatic handshake();
    @(negedge clk) rstSet = 1'b1;
    @(negedge clk) rstSet = 1'b0;
    check(rstPending === 1'b1, "R2", "pending after request", int'(rstPending), 1);
    @(negedge clk);
    check(rstPending === 1'b0, "R2", "self-clear", int'(rstPending), 0);
  endtask

  task automatic writeByte(logic [7:0] b, logic eom);
    @(negedge clk) begin wrEn = 1'b1; wrData = b; wrEom = eom; end
    @(negedge clk) begin wrEn = 1'b0; wrEom = 1'b0; end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic hold;
    int n;
    bit eom;
    string req;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(txBit === 1'b1, "R1", "txBit after reset", int'(txBit), 1);
    check(rstPending === 1'b0, "R1", "rstPending after reset", int'(rstPending), 0);
    check(fifoFull === 1'b0, "R1", "fifoFull after reset", int'(fifoFull), 0);
    buildExpect(0, 1'b0, 2);
    compareStream("R1", "power-on abort then fill");

    // R3 both fill patterns after a restart
    for (int f = 0; f < 2; f++) begin
      fillSel = f[0];
      handshake();
      buildExpect(0, 1'b0, 3);
      compareStream("R3", $sformatf("fill sel %0d", f));
    end

    // sweep over switch settings and payload patterns
    for (int cfg = 0; cfg < 8; cfg++) begin
      fillSel = cfg[0]; crcOff = cfg[1]; stuffOff = cfg[2];
      for (int p = 0; p < 6; p++) begin
        n = 1 + (p % 4);
        eom = (p != 5);
        for (int k = 0; k < n; k++)
          dat[k] = (p == 0) ? 8'hFF : (p == 1) ? 8'h7E : (p == 2) ? 8'hF8 :
                   8'(p * 37 + k * 91 + cfg * 13);
        handshake();
        for (int k = 0; k < n; k++) writeByte(dat[k], eom && (k == n - 1));
        buildExpect(n, eom, 2);
        if (!eom) req = "R9";
        else if (crcOff) req = "R6";
        else if (stuffOff) req = "R8";
        else if (p == 0) req = "R7";
        else if (p == 1) req = "R4";
        else req = "R5";
        compareStream(req, $sformatf("cfg %0d pattern %0d", cfg, p));
      end
    end

    // R11 output holds without strobe
    hold = txBit;
    repeat (6) @(negedge clk);
    check(txBit === hold, "R11", "txBit held without bitEn", int'(txBit), int'(hold));

    // R10 queue depth and ignored write when full
    fillSel = 1'b1; crcOff = 1'b0; stuffOff = 1'b0;
    handshake();
    for (int k = 0; k < DEPTH; k++) begin
      dat[k] = 8'(k * 29 + 3);
      writeByte(dat[k], k == DEPTH - 1);
      if (k == DEPTH - 2)
        check(fifoFull === 1'b0, "R10", "not full at 63", int'(fifoFull), 0);
    end
    check(fifoFull === 1'b1, "R10", "full at 64", int'(fifoFull), 1);
    writeByte(8'h55, 1'b1);
    check(fifoFull === 1'b1, "R10", "still full after extra write", int'(fifoFull), 1);
    buildExpect(DEPTH, 1'b1, 3);
    compareStream("R10", "64-byte frame, extra write dropped");

    // R2 flush and write in the same cycle
    fillSel = 1'b1;
    writeByte(8'h11, 1'b0);
    @(negedge clk) rstSet = 1'b1;
    @(negedge clk) begin rstSet = 1'b0; wrEn = 1'b1; wrData = 8'hA5; wrEom = 1'b1; end
    check(rstPending === 1'b1, "R2", "pending during collision", int'(rstPending), 1);
    @(negedge clk) begin wrEn = 1'b0; wrEom = 1'b0; end
    buildExpect(0, 1'b0, 3);
    compareStream("R2", "flush drops queued and colliding writes");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule